// File: doc/BRIEF.md
# Sticky Interrupt Controller with Read-to-Mask

This block gathers up to 26 hardware interrupt sources into one CPU interrupt line. A single-cycle pulse on any source input sets a status bit, and the bit stays set until software clears it. A per-source enable register selects which status bits may reach the CPU. A global masked flag can block all of them at once.

The block has three word registers on a 32-bit bus with byte-lane masks. The status register is at offset 0x70, the enable register at 0x74 and the mask-control register at 0x78. Reading mask control returns the prior unmasked state and masks the controller in the same access. Software can therefore enter a critical section and learn the earlier state in one bus read, then restore that state later by writing the returned value back.

Top module: `sirq_ctrl`

## Requirements
- R1: After a synchronous active-high reset, the status register, the enable register and the masked flag are all zero. The pending vector is zero.
- R2: A high bit on the source input ORs into the status register at the next clock edge, and the bit stays set with no further pulse.
- R3: A write to offset 0x70 clears each status bit written as zero inside an enabled byte lane. Status bits written as one, and status bits in disabled lanes, keep their value. A write never sets a status bit.
- R4: If a source pulses in the same cycle as a write that clears its status bit, the bit ends up set.
- R5: A write to offset 0x74 replaces the enable bits inside the enabled byte lanes and leaves the other enable bits unchanged.
- R6: A read of offset 0x78 returns 1 in bit 0 if the controller was unmasked and 0 if it was masked. From the next cycle on, the controller is masked, whatever the byte lanes of that read.
- R7: A write to offset 0x78 sets the masked flag to the inverse of write-data bit 0.
- R8: Pending-vector bit 2 is high exactly when the controller is unmasked and (status AND enable) is nonzero. All other bits of the pending vector are zero.
- R9: Read data is ANDed with the byte-lane mask, with lane n covering bits 8n+7..8n. Status and enable bits above bit 25 read as zero.
- R10: Only address bits 6..2 select a register, so address bits 1..0 are ignored. Reads of any other offset return zero, and writes to any other offset change nothing. Read data is zero in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Interrupt source pulses (bit 0 vertical blank, bit 3 DMA, bit 9 sound) |
| bus_vld_i | input | 1 | Bus access this cycle |
| bus_wr_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | ADDR_W | Byte offset within the block |
| bus_lane_i | input | 4 | Byte-lane enables |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the read |
| irq_pend_o | output | PEND_W | CPU pending vector; bit 2 is the interrupt request |

## Verification
The bench targets the clear-on-zero acknowledge. A design that cleared the bits written as one, or ignored the lane mask, would leave the wrong status bits after a partial-lane acknowledge. It checks that a source pulse arriving in the same cycle as its own acknowledge survives; a design that gave the write priority would lose that interrupt. The read-to-mask access is tested with all lanes enabled and with lane 0 disabled; a design that masked only when bit 0 was returned, or returned the new state instead of the old one, would leave the pending line wrong or return the wrong bit. Undefined offsets, and offsets with nonzero low address bits, test that decoding uses only bits 6..2.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    // word index (address bits 6..2) of each register
    localparam logic [4:0] IDX_STAT = 5'h1C;
    localparam logic [4:0] IDX_EN   = 5'h1D;
    localparam logic [4:0] IDX_MASK = 5'h1E;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_EN   = 2'd2,
        SEL_MASK = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        reg_sel_e          sel;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] bmask;
    } bus_op_t;

    function automatic logic [DATA_W-1:0] lane_expand(input logic [LANES-1:0] lanes);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < LANES; i++) begin
            m[i*8 +: 8] = {8{lanes[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/sirq_decode.sv
module sirq_decode
    import sirq_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic                    vld_i,
    input  logic                    wr_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [LANES-1:0]        lane_i,
    input  logic [DATA_W-1:0]       wdata_i,
    output bus_op_t                 op_o
);
    logic [4:0] idx;

    always_comb begin
        idx = addr_i[6:2];
        op_o.rd    = vld_i && !wr_i;
        op_o.wr    = vld_i && wr_i;
        op_o.wdata = wdata_i;
        op_o.bmask = lane_expand(lane_i);
        unique case (idx)
            IDX_STAT: op_o.sel = SEL_STAT;
            IDX_EN:   op_o.sel = SEL_EN;
            IDX_MASK: op_o.sel = SEL_MASK;
            default:  op_o.sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/sirq_status.sv
module sirq_status
    import sirq_pkg::*;
#(
    parameter int NUM_SRC = 26
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               ack_i,
    input  logic [NUM_SRC-1:0] ack_data_i,
    input  logic [NUM_SRC-1:0] ack_mask_i,
    output logic [NUM_SRC-1:0] status_o
);
    logic [NUM_SRC-1:0] keep;
    logic [NUM_SRC-1:0] status_q;

    always_comb begin
        keep = ack_i ? (ack_data_i | ~ack_mask_i) : '1;
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (status_q & keep) | src_i;
    end

    assign status_o = status_q;
endmodule

// File: rtl/sirq_enable.sv
module sirq_enable #(
    parameter int NUM_SRC = 26
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_i,
    input  logic [NUM_SRC-1:0] data_i,
    input  logic [NUM_SRC-1:0] mask_i,
    output logic [NUM_SRC-1:0] enable_o
);
    logic [NUM_SRC-1:0] enable_q;

    always_ff @(posedge clk) begin
        if (rst)       enable_q <= '0;
        else if (wr_i) enable_q <= (enable_q & ~mask_i) | (data_i & mask_i);
    end

    assign enable_o = enable_q;
endmodule

// File: rtl/sirq_maskctl.sv
module sirq_maskctl (
    input  logic clk,
    input  logic rst,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic masked_o
);
    logic masked_q;

    always_ff @(posedge clk) begin
        if (rst)       masked_q <= 1'b0;
        else if (rd_i) masked_q <= 1'b1;
        else if (wr_i) masked_q <= ~wbit_i;
    end

    assign masked_o = masked_q;
endmodule

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
    import sirq_pkg::*;
#(
    parameter int NUM_SRC  = 26,
    parameter int ADDR_W   = 7,
    parameter int PEND_W   = 8,
    parameter int PEND_BIT = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_vld_i,
    input  logic               bus_wr_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [3:0]         bus_lane_i,
    input  logic [31:0]        bus_wdata_i,
    output logic [31:0]        bus_rdata_o,
    output logic [PEND_W-1:0]  irq_pend_o
);
    bus_op_t            op;
    logic [NUM_SRC-1:0] stat_q;
    logic [NUM_SRC-1:0] en_q;
    logic               masked_q;
    logic [DATA_W-1:0]  rd_raw;

    sirq_decode #(.ADDR_W(ADDR_W)) u_dec (
        .vld_i   (bus_vld_i),
        .wr_i    (bus_wr_i),
        .addr_i  (bus_addr_i),
        .lane_i  (bus_lane_i),
        .wdata_i (bus_wdata_i),
        .op_o    (op)
    );

    sirq_status #(.NUM_SRC(NUM_SRC)) u_stat (
        .clk        (clk),
        .rst        (rst),
        .src_i      (src_i),
        .ack_i      (op.wr && op.sel == SEL_STAT),
        .ack_data_i (op.wdata[NUM_SRC-1:0]),
        .ack_mask_i (op.bmask[NUM_SRC-1:0]),
        .status_o   (stat_q)
    );

    sirq_enable #(.NUM_SRC(NUM_SRC)) u_en (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (op.wr && op.sel == SEL_EN),
        .data_i   (op.wdata[NUM_SRC-1:0]),
        .mask_i   (op.bmask[NUM_SRC-1:0]),
        .enable_o (en_q)
    );

    sirq_maskctl u_mask (
        .clk      (clk),
        .rst      (rst),
        .rd_i     (op.rd && op.sel == SEL_MASK),
        .wr_i     (op.wr && op.sel == SEL_MASK),
        .wbit_i   (op.wdata[0]),
        .masked_o (masked_q)
    );

    always_comb begin
        rd_raw = '0;
        if (op.rd) begin
            unique case (op.sel)
                SEL_STAT: rd_raw = DATA_W'(stat_q);
                SEL_EN:   rd_raw = DATA_W'(en_q);
                SEL_MASK: rd_raw = DATA_W'(!masked_q);
                default:  rd_raw = '0;
            endcase
        end
        bus_rdata_o = rd_raw & op.bmask;
    end

    always_comb begin
        irq_pend_o           = '0;
        irq_pend_o[PEND_BIT] = !masked_q && (|(stat_q & en_q));
    end

endmodule

// File: rtl/sirq_ctrl_chk.sv
module sirq_ctrl_chk #(
    parameter int NUM_SRC  = 26,
    parameter int ADDR_W   = 7,
    parameter int PEND_W   = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] src_i,
    input logic               bus_vld_i,
    input logic               bus_wr_i,
    input logic [ADDR_W-1:0]  bus_addr_i,
    input logic [3:0]         bus_lane_i,
    input logic [31:0]        bus_rdata_o,
    input logic [PEND_W-1:0]  irq_pend_o,
    input logic [NUM_SRC-1:0] stat_q,
    input logic [NUM_SRC-1:0] en_q,
    input logic               masked_q
);
    logic mask_rd, en_wr;
    assign mask_rd = bus_vld_i && !bus_wr_i && bus_addr_i[6:2] == 5'h1E;
    assign en_wr   = bus_vld_i &&  bus_wr_i && bus_addr_i[6:2] == 5'h1D;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (stat_q == '0 && en_q == '0 && !masked_q));

    assert_src_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & $past(src_i)) == $past(src_i)));

    assert_no_spurious_set_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(src_i)) == '0));

    assert_read_masks_R6: assert property (@(posedge clk) disable iff (rst)
        mask_rd |=> masked_q);

    assert_read_old_state_R6: assert property (@(posedge clk) disable iff (rst)
        (mask_rd && bus_lane_i[0]) |-> (bus_rdata_o[0] == !masked_q));

    assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        masked_q |-> (irq_pend_o == '0));

    assert_enable_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !en_wr |=> $stable(en_q));

endmodule

bind sirq_ctrl sirq_ctrl_chk #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W),
    .PEND_W  (PEND_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .src_i       (src_i),
    .bus_vld_i   (bus_vld_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_lane_i  (bus_lane_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_pend_o  (irq_pend_o),
    .stat_q      (stat_q),
    .en_q        (en_q),
    .masked_q    (masked_q)
);

// File: tb/sirq_ctrl_tb.sv
module sirq_ctrl_tb;

    localparam int NSRC = 26;
    localparam int PW   = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] src = '0;
    logic            vld = 1'b0;
    logic            wr  = 1'b0;
    logic [6:0]      addr = '0;
    logic [3:0]      lane = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [PW-1:0]   pend;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sirq_ctrl #(.NUM_SRC(NSRC), .ADDR_W(7), .PEND_W(PW), .PEND_BIT(2)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .src_i       (src),
        .bus_vld_i   (vld),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_lane_i  (lane),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_pend_o  (pend)
    );

    // op: 0 idle, 1 write, 2 read
    typedef struct packed {
        logic [3:0]      req;
        logic [1:0]      op;
        logic [6:0]      addr;
        logic [3:0]      lane;
        logic [31:0]     wd;
        logic [NSRC-1:0] src;
        logic [31:0]     exp_rd;
        logic            exp_pend;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VECS [NV] = '{
        '{4'd1,  2'd2, 7'h70, 4'hF, 32'h0,        26'h0,       32'h0,        1'b0}, // R1
        '{4'd1,  2'd2, 7'h74, 4'hF, 32'h0,        26'h0,       32'h0,        1'b0}, // R1
        '{4'd2,  2'd0, 7'h00, 4'h0, 32'h0,        26'h209,     32'h0,        1'b0}, // R2
        '{4'd2,  2'd2, 7'h70, 4'hF, 32'h0,        26'h0,       32'h209,      1'b0}, // R2
        '{4'd5,  2'd1, 7'h74, 4'h1, 32'hFFFFFFFF, 26'h0,       32'h0,        1'b1}, // R5
        '{4'd5,  2'd2, 7'h74, 4'hF, 32'h0,        26'h0,       32'hFF,       1'b1}, // R5
        '{4'd3,  2'd1, 7'h70, 4'h1, 32'hFFFFFFF6, 26'h0,       32'h0,        1'b0}, // R3
        '{4'd3,  2'd2, 7'h70, 4'hF, 32'h0,        26'h0,       32'h200,      1'b0}, // R3
        '{4'd5,  2'd1, 7'h74, 4'h2, 32'h00000200, 26'h0,       32'h0,        1'b1}, // R5
        '{4'd5,  2'd2, 7'h74, 4'hF, 32'h0,        26'h0,       32'h2FF,      1'b1}, // R5
        '{4'd6,  2'd2, 7'h78, 4'hF, 32'h0,        26'h0,       32'h1,        1'b0}, // R6
        '{4'd6,  2'd2, 7'h78, 4'hF, 32'h0,        26'h0,       32'h0,        1'b0}, // R6
        '{4'd7,  2'd1, 7'h78, 4'hF, 32'h1,        26'h0,       32'h0,        1'b1}, // R7
        '{4'd7,  2'd1, 7'h78, 4'hF, 32'h0,        26'h0,       32'h0,        1'b0}, // R7
        '{4'd7,  2'd1, 7'h78, 4'hF, 32'h2,        26'h0,       32'h0,        1'b0}, // R7
        '{4'd7,  2'd1, 7'h78, 4'hF, 32'hFFFFFFFF, 26'h0,       32'h0,        1'b1}, // R7
        '{4'd4,  2'd1, 7'h70, 4'hF, 32'hFFFFFDFF, 26'h200,     32'h0,        1'b1}, // R4
        '{4'd9,  2'd2, 7'h70, 4'h2, 32'h0,        26'h0,       32'h200,      1'b1}, // R9
        '{4'd9,  2'd2, 7'h70, 4'h1, 32'h0,        26'h0,       32'h0,        1'b1}, // R9
        '{4'd10, 2'd1, 7'h40, 4'hF, 32'h0,        26'h0,       32'h0,        1'b1}, // R10
        '{4'd10, 2'd2, 7'h40, 4'hF, 32'h0,        26'h0,       32'h0,        1'b1}, // R10
        '{4'd10, 2'd2, 7'h7C, 4'hF, 32'h0,        26'h0,       32'h0,        1'b1}, // R10
        '{4'd10, 2'd2, 7'h73, 4'hF, 32'h0,        26'h0,       32'h200,      1'b1}, // R10
        '{4'd3,  2'd1, 7'h70, 4'hF, 32'h0,        26'h0,       32'h0,        1'b0}, // R3
        '{4'd2,  2'd0, 7'h00, 4'h0, 32'h0,        26'h2000000, 32'h0,        1'b0}, // R2
        '{4'd9,  2'd2, 7'h70, 4'h8, 32'h0,        26'h0,       32'h02000000, 1'b0}, // R9
        '{4'd3,  2'd1, 7'h70, 4'hF, 32'hFFFFFFFF, 26'h0,       32'h0,        1'b0}, // R3
        '{4'd3,  2'd2, 7'h70, 4'hF, 32'h0,        26'h0,       32'h02000000, 1'b0}, // R3
        '{4'd8,  2'd1, 7'h74, 4'h8, 32'h02000000, 26'h0,       32'h0,        1'b1}, // R8
        '{4'd5,  2'd2, 7'h74, 4'hF, 32'h0,        26'h0,       32'h020002FF, 1'b1}, // R5
        '{4'd6,  2'd2, 7'h78, 4'h2, 32'h0,        26'h0,       32'h0,        1'b0}, // R6
        '{4'd6,  2'd2, 7'h78, 4'hF, 32'h0,        26'h0,       32'h0,        1'b0}, // R6
        '{4'd7,  2'd1, 7'h78, 4'hF, 32'h1,        26'h0,       32'h0,        1'b1}, // R7
        '{4'd3,  2'd1, 7'h70, 4'h8, 32'h00FFFFFF, 26'h0,       32'h0,        1'b0}  // R3
    };

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [6:0] a, input logic [3:0] l,
                         input logic [31:0] d, input logic [NSRC-1:0] s);
        vld   = (op != 2'd0);
        wr    = (op == 2'd1);
        addr  = a;
        lane  = l;
        wdata = d;
        src   = s;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1", "pend after reset", 32'(pend), 32'h0);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i].op, VECS[i].addr, VECS[i].lane, VECS[i].wd, VECS[i].src);
            #1;
            check($sformatf("R%0d row%0d", VECS[i].req, i), "rdata", rdata, VECS[i].exp_rd);
            @(posedge clk);
            #1;
            // R8: only bit 2 of the vector may be set
            check($sformatf("R%0d row%0d", VECS[i].req, i), "pend",
                  32'(pend), 32'(VECS[i].exp_pend) << 2);
            drive(2'd0, 7'h0, 4'h0, 32'h0, '0);
        end

        // R1: reset in the middle of activity clears all state
        @(negedge clk);
        drive(2'd1, 7'h74, 4'hF, 32'hFFFFFFFF, 26'h8);
        @(negedge clk);
        drive(2'd0, 7'h0, 4'h0, 32'h0, '0);
        #1;
        check("R8", "pend before reset", 32'(pend), 32'h4);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", "pend after mid reset", 32'(pend), 32'h0);
        drive(2'd2, 7'h70, 4'hF, 32'h0, '0);
        #1;
        check("R1", "status after mid reset", rdata, 32'h0);
        drive(2'd2, 7'h74, 4'hF, 32'h0, '0);
        #1;
        check("R1", "enable after mid reset", rdata, 32'h0);
        drive(2'd2, 7'h78, 4'hF, 32'h0, '0);
        #1;
        check("R1", "unmasked after mid reset", rdata, 32'h1);
        @(negedge clk);
        drive(2'd0, 7'h0, 4'h0, 32'h0, '0);
        #1;
        check("R10", "rdata idle", rdata, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule